// File: doc/BRIEF.md
# Dual-Mode Fractional/Integer Multiplier

This block is the multiply stage in front of a 40-bit accumulator. It takes two 16-bit operands. A separate flag for each operand says whether that operand is signed or unsigned, so signed, unsigned and mixed-sign products all come from the same hardware. Each operand gains one extra top bit, filled from its sign or with zero. The two widened operands go into a single 17x17 two's-complement multiply.

A scaler follows the multiply and sets the result format. In integer mode the product is used as it is. In fractional mode the product moves left by one place, which turns the product of two Q15 values into a 1.31 value. The 33-bit scaler output is sign-extended to the 40-bit width of the accumulator. A separate byte mode multiplies only the low 8 bits of each operand and gives a 16-bit product. That product is widened to 40 bits according to the operand signedness.

Operands and mode flags are sampled on a valid strobe. The 40-bit result and a one-cycle result-valid flag appear on the next clock. Rounding, saturation and accumulation are done further down the datapath.

Top module: `mulq_dual_mode`

## Requirements
- R1: While reset is asserted, and after it is released, `res_q` reads zero and `res_valid` reads 0 until the first strobe is taken.
- R2: In word mode, an operand whose flag is 1 is sign-extended into its 17th bit, and an operand whose flag is 0 is zero-extended. For example, 0xFFFF times 0x0001 gives 65535 when both operands are unsigned. The same pair gives -1 (all 40 bits set) when both operands are signed.
- R3: In word integer mode (`frac_mode`=0, `byte_mode`=0), the 33-bit scaler output equals the two's-complement product of the widened operands. That product always fits in 33 bits.
- R4: In word fractional mode (`frac_mode`=1), the scaler output is the product shifted left by one bit, with 0 in bit 0. Bits beyond 33 are discarded.
- R5: In fractional mode with both operands signed, 0x8000 times 0x8000 gives +1.0 in Q31, which is 0x00_8000_0000 on the 40-bit output. No saturation is applied.
- R6: In word mode, bits 39..33 of the result repeat bit 32.
- R7: When `byte_mode`=1, only bits 7..0 of each operand are used, widened to 9 bits by their flags. The 16-bit product sits in bits 15..0. Bits 39..16 repeat bit 15 if either operand is signed, and are zero if both are unsigned. Bits 15..8 of the operands have no effect.
- R8: When `byte_mode`=1, `frac_mode` has no effect on the result.
- R9: A strobe on `in_valid` at clock edge n makes the new result visible, with `res_valid`=1, after edge n+1. `res_valid` is 1 for exactly one cycle per strobe.
- R10: A clock edge with `in_valid`=0 leaves `res_q` unchanged, whatever the operands and modes are at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; the inputs are sampled on an edge where it is high |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| a_sgn | input | 1 | 1: `op_a` is signed, 0: unsigned |
| b_sgn | input | 1 | 1: `op_b` is signed, 0: unsigned |
| frac_mode | input | 1 | 1: fractional (1.31) scaling, 0: integer |
| byte_mode | input | 1 | 1: 8-bit operands with a 16-bit product, 0: 16-bit operands |
| res_q | output | 40 | Registered, sign-extended result |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hardest cases to reach are at the ends of the widened-operand range. One is the fractional square of -1.0, which reaches exactly +1.0 and sets bit 31 while bit 32 stays clear. The other is the fully unsigned 0xFFFF square, where the top of the 33-bit product is in use. The stimulus sweeps a list of word operands chosen at sign and magnitude boundaries, through every signedness and scaling combination, so both cases occur along with their mixed-sign neighbours. Byte mode is swept on a strided grid over both low bytes with junk in the upper bytes and alternating `frac_mode`, so any leak of ignored bits shows up in the result. Each strobe is followed by an idle edge with changed inputs, which shows the hold behaviour and the end of the valid pulse.

// File: rtl/mulq_pkg.sv
package mulq_pkg;

  // mode bits sampled together with the operands
  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic frac;
    logic byte_sel;
  } mulq_mode_t;

  // Fill bit used above a narrow product: the product's top bit if either
  // factor was signed, otherwise zero.
  function automatic logic mulq_fill(input logic a_sgn, input logic b_sgn,
                                     input logic top_bit);
    return (a_sgn | b_sgn) & top_bit;
  endfunction

endpackage

// File: rtl/mulq_widen.sv
module mulq_widen #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 17
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             sgn_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  logic pad_bit;
  assign pad_bit = sgn_i & val_i[IN_W-1];
  assign val_o   = {{PAD_W{pad_bit}}, val_i};
endmodule

// File: rtl/mulq_core.sv
module mulq_core
  import mulq_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned SUB_W = 8,
  parameter int unsigned RES_W = 40
) (
  input  logic [OP_W-1:0]      op_a,
  input  logic [OP_W-1:0]      op_b,
  input  mulq_mode_t           mode,
  output logic [2*OP_W+1:0]    raw_word,
  output logic [2*SUB_W+1:0]   raw_byte,
  output logic [RES_W-1:0]     result
);
  localparam int unsigned EXT_W  = OP_W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;
  localparam int unsigned SCL_W  = 2 * OP_W + 1;
  localparam int unsigned BEXT_W = SUB_W + 1;
  localparam int unsigned BPRD_W = 2 * BEXT_W;
  localparam int unsigned BRES_W = 2 * SUB_W;

  logic [EXT_W-1:0]  wide_a, wide_b;
  logic [BEXT_W-1:0] nar_a, nar_b;

  // one widening unit per operand and per operand size
  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic [OP_W-1:0] src;
    logic            sgn;
    assign src = (g == 0) ? op_a : op_b;
    assign sgn = (g == 0) ? mode.a_sgn : mode.b_sgn;

    logic [EXT_W-1:0]  w_out;
    logic [BEXT_W-1:0] n_out;

    mulq_widen #(.IN_W(OP_W), .OUT_W(EXT_W)) u_word (
      .val_i(src), .sgn_i(sgn), .val_o(w_out)
    );
    mulq_widen #(.IN_W(SUB_W), .OUT_W(BEXT_W)) u_byte (
      .val_i(src[SUB_W-1:0]), .sgn_i(sgn), .val_o(n_out)
    );
  end

  assign wide_a = g_ext[0].w_out;
  assign wide_b = g_ext[1].w_out;
  assign nar_a  = g_ext[0].n_out;
  assign nar_b  = g_ext[1].n_out;

  // word path: signed 17x17 product, then scaler
  logic signed [PROD_W-1:0] word_prod;
  assign word_prod = PROD_W'($signed(wide_a)) * PROD_W'($signed(wide_b));
  assign raw_word  = word_prod;

  logic [SCL_W-1:0] scaled;
  assign scaled = mode.frac ? {word_prod[SCL_W-2:0], 1'b0}
                            : word_prod[SCL_W-1:0];

  logic [RES_W-1:0] word_res;
  assign word_res = {{(RES_W-SCL_W){scaled[SCL_W-1]}}, scaled};

  // byte path: signed 9x9 product, 16-bit result widened by signedness
  logic signed [BPRD_W-1:0] byte_prod;
  assign byte_prod = BPRD_W'($signed(nar_a)) * BPRD_W'($signed(nar_b));
  assign raw_byte  = byte_prod;

  logic [BRES_W-1:0] byte_lo;
  logic              byte_fill;
  assign byte_lo   = byte_prod[BRES_W-1:0];
  assign byte_fill = mulq_fill(mode.a_sgn, mode.b_sgn, byte_lo[BRES_W-1]);

  logic [RES_W-1:0] byte_res;
  assign byte_res = {{(RES_W-BRES_W){byte_fill}}, byte_lo};

  assign result = mode.byte_sel ? byte_res : word_res;
endmodule

// File: rtl/mulq_outreg.sv
module mulq_outreg #(
  parameter int unsigned RES_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [RES_W-1:0] next_i,
  output logic [RES_W-1:0] res_q,
  output logic             res_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= take_i;
      if (take_i) res_q <= next_i;
    end
  end
endmodule

// File: rtl/mulq_dual_mode.sv
module mulq_dual_mode
  import mulq_pkg::*;
#(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned SUB_W = 8,
  parameter int unsigned RES_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             a_sgn,
  input  logic             b_sgn,
  input  logic             frac_mode,
  input  logic             byte_mode,
  output logic [RES_W-1:0] res_q,
  output logic             res_valid
);
  localparam int unsigned RAWW_W = 2 * OP_W + 2;
  localparam int unsigned RAWB_W = 2 * SUB_W + 2;

  mulq_mode_t       mode;
  logic [RAWW_W-1:0] raw_word;
  logic [RAWB_W-1:0] raw_byte;
  logic [RES_W-1:0]  next_res;

  assign mode = '{a_sgn: a_sgn, b_sgn: b_sgn, frac: frac_mode, byte_sel: byte_mode};

  mulq_core #(.OP_W(OP_W), .SUB_W(SUB_W), .RES_W(RES_W)) u_core (
    .op_a(op_a), .op_b(op_b), .mode(mode),
    .raw_word(raw_word), .raw_byte(raw_byte), .result(next_res)
  );

  mulq_outreg #(.RES_W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n), .take_i(in_valid), .next_i(next_res),
    .res_q(res_q), .res_valid(res_valid)
  );
endmodule

// File: rtl/mulq_chk.sv
module mulq_chk #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned SUB_W = 8,
  parameter int unsigned RES_W = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               a_sgn,
  input logic               b_sgn,
  input logic               frac_mode,
  input logic               byte_mode,
  input logic [RES_W-1:0]   res_q,
  input logic               res_valid,
  input logic [2*OP_W+1:0]  raw_word,
  input logic [2*SUB_W+1:0] raw_byte
);
  localparam int unsigned SCL_W = 2 * OP_W + 1;
  localparam int unsigned RW_T  = 2 * OP_W + 1;
  localparam int unsigned RB_T  = 2 * SUB_W + 1;

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);  // R9
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_q));  // R10
  AST_GUARD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((&res_q[RES_W-1:SCL_W-1]) || !(|res_q[RES_W-1:SCL_W-1])));  // R6
  AST_FRAC_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(frac_mode) && !$past(byte_mode)) |-> !res_q[0]);  // R4
  AST_WORD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_word[RW_T] == raw_word[RW_T-1]);  // R3
  AST_BYTE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_byte[RB_T] == raw_byte[RB_T-1]);  // R7
  AST_BYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(byte_mode) && !$past(a_sgn) && !$past(b_sgn))
      |-> !(|res_q[RES_W-1:2*SUB_W]));  // R7
endmodule

bind mulq_dual_mode mulq_chk #(.OP_W(OP_W), .SUB_W(SUB_W), .RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sgn(a_sgn), .b_sgn(b_sgn),
  .frac_mode(frac_mode), .byte_mode(byte_mode), .res_q(res_q),
  .res_valid(res_valid), .raw_word(raw_word), .raw_byte(raw_byte)
);

// File: tb/mulq_dual_mode_tb.sv
`timescale 1ns/1ps
module mulq_dual_mode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        a_sgn = 1'b0, b_sgn = 1'b0, frac_mode = 1'b0, byte_mode = 1'b0;
  logic [39:0] res_q;
  logic        res_valid;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;
  logic [39:0] last_exp = '0;

  always #2 clk = ~clk;

  mulq_dual_mode dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_sgn(a_sgn), .b_sgn(b_sgn), .frac_mode(frac_mode), .byte_mode(byte_mode),
    .res_q(res_q), .res_valid(res_valid)
  );

  // reference arithmetic written with plain integer math
  function automatic logic [39:0] ref_mul(input logic [15:0] a, input logic [15:0] b,
                                          input bit as, input bit bs,
                                          input bit fr, input bit by);
    longint va, vb, p;
    logic [63:0] pv;
    logic [15:0] lo;
    logic [32:0] p33;
    if (by) begin
      va = as ? longint'($signed(a[7:0])) : longint'(a[7:0]);
      vb = bs ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      p  = va * vb;
      pv = p;
      lo = pv[15:0];
      if (as || bs) return {{24{lo[15]}}, lo};
      return {24'd0, lo};
    end
    va = as ? longint'($signed(a)) : longint'(a);
    vb = bs ? longint'($signed(b)) : longint'(b);
    p  = va * vb;
    if (fr) p = p * 2;
    pv  = p;
    p33 = pv[32:0];
    return {{7{p33[32]}}, p33};
  endfunction

  task automatic check(input string tag, input logic [39:0] got, input logic [39:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one strobe followed by one idle edge with scrambled inputs
  task automatic apply(input string tag, input logic [15:0] a, input logic [15:0] b,
                       input bit as, input bit bs, input bit fr, input bit by);
    logic [39:0] e;
    @(negedge clk);
    check("R9 valid low between strobes", {39'd0, res_valid}, 40'd0);
    check("R10 result held on idle edge", res_q, last_exp);
    op_a = a; op_b = b; a_sgn = as; b_sgn = bs; frac_mode = fr; byte_mode = by;
    in_valid = 1'b1;
    e = ref_mul(a, b, as, bs, fr, by);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 valid one cycle after strobe", {39'd0, res_valid}, 40'd1);
    check(tag, res_q, e);
    last_exp = e;
    op_a = ~a; op_b = b ^ 16'h5A5A; a_sgn = ~as; frac_mode = ~fr; byte_mode = ~by;
  endtask

  initial begin
    logic [15:0] wv [12];
    wv = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001,
           16'hFFFF, 16'h1234, 16'hC000, 16'h4000, 16'h00FF, 16'hA5A5};
    repeat (3) @(negedge clk);
    check("R1 reset result", res_q, 40'd0);
    check("R1 reset valid", {39'd0, res_valid}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 result after release", res_q, 40'd0);

    apply("R2 unsigned 0xFFFF*1", 16'hFFFF, 16'h0001, 0, 0, 0, 0);
    check("R2 unsigned value", res_q, 40'h00_0000_FFFF);
    apply("R2 signed 0xFFFF*1", 16'hFFFF, 16'h0001, 1, 1, 0, 0);
    check("R2 signed value", res_q, 40'hFF_FFFF_FFFF);
    apply("R5 frac -1.0 squared", 16'h8000, 16'h8000, 1, 1, 1, 0);
    check("R5 +1.0 unsaturated", res_q, 40'h00_8000_0000);
    apply("R3 unsigned max square", 16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
    check("R3 value", res_q, 40'h00_FFFE_0001);

    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int s = 0; s < 4; s++)
          for (int f = 0; f < 2; f++)
            apply(f ? "R4 R6 word fractional" : "R3 R6 word integer",
                  wv[i], wv[j], s[1], s[0], f[0], 1'b0);

    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 5)
        for (int s = 0; s < 4; s++)
          apply("R7 R8 byte mode",
                {8'(a * 37 + 11), 8'(a)}, {8'(b * 91 + 5), 8'(b)},
                s[1], s[0], (a ^ b) & 1, 1'b1);

    @(negedge clk);
    check("R9 valid drops", {39'd0, res_valid}, 40'd0);
    check("R10 final hold", res_q, last_exp);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule